// File: doc/BRIEF.md
# Watchdog-Capable Free-Running Timer with Cross-Domain Count Access

The block keeps a free-running count in a slow tick clock domain (nominally a 3 MHz tick) and exposes it, together with a bank of match registers, through a simple register port on a faster bus clock. Every match register has a sticky status bit. An interrupt level is raised when any enabled status bit is set. Match register 0 doubles as a watchdog deadline. While the watchdog is armed and the count reaches that deadline, a sticky reset-status flag is set and a reset request is driven to the reset controller. Software keeps the system alive by rewriting match 0 to the current count plus a margin.

The count lives in the tick domain, so the bus never samples it directly. To read it, software sets a request bit and polls a read-busy flag. When the flag drops, the count register returns a snapshot taken in the tick domain, and that snapshot stays fixed until the next request. To write it, software waits for a write-busy flag to read clear and then writes the count register. The value is handed to the tick domain through a toggle handshake, and any further count write made while the flag is set is discarded. Match values cross into the tick domain through a synchronizer that only accepts a value once two successive samples agree.

Byte offsets: 0x00 control (bit 0 run, bit 1 read request, write-only strobe), 0x04 access status (bit 0 read busy, bit 1 write busy), 0x08 count, 0x0C match status (bit i for match i, write 1 to clear), 0x10 interrupt enable (bit i for match i), 0x14 watchdog arm (bit 0), 0x18 reset status (bit 3 watchdog reset, write 1 to clear), and 0x20 + 4*i match register i.

Top module: `wdt_ostimer`

## Requirements
- R1: After reset, every register reads 0, and both irq and wdt_reset_req are low.
- R2: A write to count (0x08) while access-status bit 1 is clear sets bit 1. Bit 1 clears once the tick domain has loaded the value. With run stopped, a later handshake read returns exactly the written value.
- R3: A count write made while access-status bit 1 is set is ignored. A later read returns the earlier value.
- R4: Writing control bit 1 sets access-status bit 0 on the next cycle. Bit 0 clears after the synchronizer round trip. Count then returns one snapshot, which stays unchanged on repeated reads until the next request, even while the counter runs.
- R5: The count advances by one per tick only while control bit 0 is 1. Writing 0 to control holds the count.
- R6: When the running count equals match i, status bit i is set and stays set until 1 is written to that bit.
- R7: irq is high exactly when some status bit i and enable bit i are both 1. Masked status bits do not raise it.
- R8: The count wraps from all ones to 0, and a match value just past the wrap is still detected.
- R9: With arm bit 0 set, a match-0 event sets reset-status bit 3 and drives wdt_reset_req high.
- R10: With arm bit 0 clear, a match-0 event sets status bit 0 but leaves reset-status bit 3 and wdt_reset_req low.
- R11: Reset-status bit 3 and wdt_reset_req stay set until 1 is written to bit 3. Writing 0 to bit 3 has no effect.
- R12: Rewriting match 0 to the current count plus a margin, more often than the margin elapses, keeps the watchdog from firing while armed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_bus | input | 1 | Register-port clock |
| rst_bus | input | 1 | Synchronous active-high reset, bus domain |
| clk_tick | input | 1 | Slow count clock |
| rst_tick | input | 1 | Synchronous active-high reset, tick domain |
| reg_sel | input | 1 | Register access strobe |
| reg_wr | input | 1 | 1 = write, 0 = read |
| reg_addr | input | ADDR_W | Byte address |
| reg_wdata | input | CNT_W | Write data |
| reg_rdata | output | CNT_W | Read data, valid the cycle after the read strobe |
| irq | output | 1 | Level interrupt, enabled status OR |
| wdt_reset_req | output | 1 | Watchdog reset request, held until cleared |

## Verification
Two situations are hard to reach from the ports.

The first is the write-while-busy case. It is reached by issuing a second count write on the bus cycle directly after the first one, inside the few ticks before the tick domain acknowledges the first.

The second is the keepalive case. Its difficulty is that no reset must occur while the counter runs well past the original deadline. It is reached by repeated handshake reads of the count, each followed by a rewrite of match 0 at a margin that exceeds the handshake and synchronizer latency.

Wrap-around matching is reached by loading a count just below all ones, so the match event occurs within a few ticks.

// File: rtl/wdt_ostimer_pkg.sv
package wdt_ostimer_pkg;
  // byte offsets of the register port
  localparam int OFS_CTRL   = 'h00;
  localparam int OFS_ACCESS = 'h04;
  localparam int OFS_COUNT  = 'h08;
  localparam int OFS_STATUS = 'h0C;
  localparam int OFS_IEN    = 'h10;
  localparam int OFS_ARM    = 'h14;
  localparam int OFS_RSTAT  = 'h18;
  localparam int OFS_MATCH0 = 'h20;

  // field positions
  localparam int BIT_RUN    = 0;
  localparam int BIT_RDREQ  = 1;
  localparam int BIT_RDBUSY = 0;
  localparam int BIT_WRBUSY = 1;
  localparam int BIT_WDRST  = 3;
endpackage

// File: rtl/wdt_tog_sync.sv
module wdt_tog_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic tog_in,
  output logic pulse
);
  logic [STAGES-1:0] sh;
  logic              last;

  always_ff @(posedge clk) begin
    if (rst) begin
      sh   <= '0;
      last <= 1'b0;
    end else begin
      sh   <= {sh[STAGES-2:0], tog_in};
      last <= sh[STAGES-1];
    end
  end

  // one destination cycle per source toggle
  assign pulse = sh[STAGES-1] ^ last;
endmodule

// File: rtl/wdt_qs_sync.sv
module wdt_qs_sync #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] din,
  output logic [W-1:0] dout
);
  logic [W-1:0] s1, s2;

  always_ff @(posedge clk) begin
    if (rst) begin
      s1   <= '0;
      s2   <= '0;
      dout <= '0;
    end else begin
      s1 <= din;
      s2 <= s1;
      // accept a quasi-static value only once two samples agree
      if (s1 == s2) dout <= s2;
    end
  end
endmodule

// File: rtl/wdt_tick_core.sv
module wdt_tick_core #(
  parameter int CNT_W     = 32,
  parameter int NUM_MATCH = 8,
  parameter int SYNC_ST   = 2
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic                       run_async,
  input  logic                       rd_req_tgl,
  input  logic                       wr_req_tgl,
  input  logic [CNT_W-1:0]           wr_val,
  input  logic [NUM_MATCH*CNT_W-1:0] match_flat,
  output logic                       rd_ack_tgl,
  output logic                       wr_ack_tgl,
  output logic [CNT_W-1:0]           snap,
  output logic [NUM_MATCH-1:0]       hit_tgl
);
  logic [SYNC_ST-1:0] run_sh;
  logic               run_s;
  logic               rd_pulse, wr_pulse;
  logic [CNT_W-1:0]   count;
  logic [CNT_W-1:0]   m_eff [NUM_MATCH];

  always_ff @(posedge clk) begin
    if (rst) run_sh <= '0;
    else     run_sh <= {run_sh[SYNC_ST-2:0], run_async};
  end
  assign run_s = run_sh[SYNC_ST-1];

  wdt_tog_sync #(.STAGES(SYNC_ST)) u_rd_sync (
    .clk(clk), .rst(rst), .tog_in(rd_req_tgl), .pulse(rd_pulse));
  wdt_tog_sync #(.STAGES(SYNC_ST)) u_wr_sync (
    .clk(clk), .rst(rst), .tog_in(wr_req_tgl), .pulse(wr_pulse));

  for (genvar i = 0; i < NUM_MATCH; i++) begin : g_msync
    wdt_qs_sync #(.W(CNT_W)) u_msync (
      .clk(clk), .rst(rst),
      .din(match_flat[i*CNT_W +: CNT_W]),
      .dout(m_eff[i]));
  end

  // counter: a bus load wins over the increment; wraps naturally
  always_ff @(posedge clk) begin
    if (rst)           count <= '0;
    else if (wr_pulse) count <= wr_val;
    else if (run_s)    count <= count + 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      snap       <= '0;
      rd_ack_tgl <= 1'b0;
      wr_ack_tgl <= 1'b0;
    end else begin
      if (rd_pulse) begin
        snap       <= count;
        rd_ack_tgl <= ~rd_ack_tgl;
      end
      if (wr_pulse) wr_ack_tgl <= ~wr_ack_tgl;
    end
  end

  // one event per pass of the running count over a match value
  always_ff @(posedge clk) begin
    if (rst) hit_tgl <= '0;
    else begin
      for (int i = 0; i < NUM_MATCH; i++) begin
        if (run_s && !wr_pulse && (count == m_eff[i]))
          hit_tgl[i] <= ~hit_tgl[i];
      end
    end
  end

  AST_CNT_HOLD: assert property (@(posedge clk) disable iff (rst)
    (!run_s && !wr_pulse) |=> $stable(count)); // R5
  AST_SNAP_ON_REQ: assert property (@(posedge clk) disable iff (rst)
    !rd_pulse |=> $stable(snap)); // R4
endmodule

// File: rtl/wdt_bus_regs.sv
module wdt_bus_regs
  import wdt_ostimer_pkg::*;
#(
  parameter int CNT_W     = 32,
  parameter int NUM_MATCH = 8,
  parameter int ADDR_W    = 8,
  parameter int SYNC_ST   = 2
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic                       reg_sel,
  input  logic                       reg_wr,
  input  logic [ADDR_W-1:0]          reg_addr,
  input  logic [CNT_W-1:0]           reg_wdata,
  output logic [CNT_W-1:0]           reg_rdata,
  output logic                       irq,
  output logic                       wdt_reset_req,
  output logic                       run_out,
  output logic                       rd_req_tgl,
  output logic                       wr_req_tgl,
  output logic [CNT_W-1:0]           wr_val,
  output logic [NUM_MATCH*CNT_W-1:0] match_flat,
  input  logic                       rd_ack_tgl,
  input  logic                       wr_ack_tgl,
  input  logic [CNT_W-1:0]           tick_snap,
  input  logic [NUM_MATCH-1:0]       hit_tgl
);
  localparam int IDX_W = (NUM_MATCH > 1) ? $clog2(NUM_MATCH) : 1;

  logic                 rd_busy, wr_busy;
  logic                 rd_ack_p, wr_ack_p;
  logic [NUM_MATCH-1:0] hit_p;
  logic [CNT_W-1:0]     snap_q;
  logic [NUM_MATCH-1:0] status_q, ien_q;
  logic                 arm_q, wdrst_q;
  logic [CNT_W-1:0]     match_q [NUM_MATCH];

  logic                 wr_en, rd_en;
  logic                 hit_ctrl, hit_count, hit_status, hit_ien, hit_arm, hit_rstat;
  logic                 hit_match;
  logic [ADDR_W-1:0]    moff;
  logic [IDX_W-1:0]     midx;

  wdt_tog_sync #(.STAGES(SYNC_ST)) u_rdack (
    .clk(clk), .rst(rst), .tog_in(rd_ack_tgl), .pulse(rd_ack_p));
  wdt_tog_sync #(.STAGES(SYNC_ST)) u_wrack (
    .clk(clk), .rst(rst), .tog_in(wr_ack_tgl), .pulse(wr_ack_p));

  for (genvar i = 0; i < NUM_MATCH; i++) begin : g_hit
    wdt_tog_sync #(.STAGES(SYNC_ST)) u_hit (
      .clk(clk), .rst(rst), .tog_in(hit_tgl[i]), .pulse(hit_p[i]));
    assign match_flat[i*CNT_W +: CNT_W] = match_q[i];
  end

  // address decode
  always_comb begin
    wr_en      = reg_sel & reg_wr;
    rd_en      = reg_sel & ~reg_wr;
    hit_ctrl   = (reg_addr == ADDR_W'(OFS_CTRL));
    hit_count  = (reg_addr == ADDR_W'(OFS_COUNT));
    hit_status = (reg_addr == ADDR_W'(OFS_STATUS));
    hit_ien    = (reg_addr == ADDR_W'(OFS_IEN));
    hit_arm    = (reg_addr == ADDR_W'(OFS_ARM));
    hit_rstat  = (reg_addr == ADDR_W'(OFS_RSTAT));
    moff       = reg_addr - ADDR_W'(OFS_MATCH0);
    hit_match  = (reg_addr >= ADDR_W'(OFS_MATCH0)) && (moff[1:0] == 2'b00) &&
                 (moff[ADDR_W-1:2] < (ADDR_W-2)'(NUM_MATCH));
    midx       = moff[IDX_W+1:2];
  end

  // control, handshakes
  always_ff @(posedge clk) begin
    if (rst) begin
      run_out    <= 1'b0;
      rd_busy    <= 1'b0;
      rd_req_tgl <= 1'b0;
      wr_busy    <= 1'b0;
      wr_req_tgl <= 1'b0;
      wr_val     <= '0;
      snap_q     <= '0;
    end else begin
      if (wr_en && hit_ctrl) begin
        run_out <= reg_wdata[BIT_RUN];
        if (reg_wdata[BIT_RDREQ] && !rd_busy) begin
          rd_busy    <= 1'b1;
          rd_req_tgl <= ~rd_req_tgl;
        end
      end
      if (rd_ack_p) begin
        rd_busy <= 1'b0;
        snap_q  <= tick_snap;
      end
      if (wr_en && hit_count && !wr_busy) begin
        wr_val     <= reg_wdata;
        wr_busy    <= 1'b1;
        wr_req_tgl <= ~wr_req_tgl;
      end else if (wr_ack_p) begin
        wr_busy <= 1'b0;
      end
    end
  end

  // status, enables, watchdog
  always_ff @(posedge clk) begin
    if (rst) begin
      status_q <= '0;
      ien_q    <= '0;
      arm_q    <= 1'b0;
      wdrst_q  <= 1'b0;
      irq      <= 1'b0;
    end else begin
      status_q <= (status_q & ~((wr_en && hit_status) ? reg_wdata[NUM_MATCH-1:0]
                                                      : {NUM_MATCH{1'b0}})) | hit_p;
      if (wr_en && hit_ien) ien_q <= reg_wdata[NUM_MATCH-1:0];
      if (wr_en && hit_arm) arm_q <= reg_wdata[0];
      if (hit_p[0] && arm_q)
        wdrst_q <= 1'b1;
      else if (wr_en && hit_rstat && reg_wdata[BIT_WDRST])
        wdrst_q <= 1'b0;
      irq <= |(status_q & ien_q);
    end
  end
  assign wdt_reset_req = wdrst_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < NUM_MATCH; i++) match_q[i] <= '0;
    end else if (wr_en && hit_match) begin
      match_q[midx] <= reg_wdata;
    end
  end

  // registered read mux
  always_ff @(posedge clk) begin
    if (rst) reg_rdata <= '0;
    else if (rd_en) begin
      reg_rdata <= '0;
      if (hit_ctrl)   reg_rdata[BIT_RUN] <= run_out;
      if (hit_count)  reg_rdata <= snap_q;
      if (hit_status) reg_rdata[NUM_MATCH-1:0] <= status_q;
      if (hit_ien)    reg_rdata[NUM_MATCH-1:0] <= ien_q;
      if (hit_arm)    reg_rdata[0] <= arm_q;
      if (hit_rstat)  reg_rdata[BIT_WDRST] <= wdrst_q;
      if (hit_match)  reg_rdata <= match_q[midx];
      if (reg_addr == ADDR_W'(OFS_ACCESS)) begin
        reg_rdata[BIT_RDBUSY] <= rd_busy;
        reg_rdata[BIT_WRBUSY] <= wr_busy;
      end
    end
  end

  AST_WR_IGNORED_BUSY: assert property (@(posedge clk) disable iff (rst)
    (wr_en && hit_count && wr_busy) |=> $stable(wr_val)); // R3
  AST_RDBUSY_ON_REQ: assert property (@(posedge clk) disable iff (rst)
    (wr_en && hit_ctrl && reg_wdata[BIT_RDREQ]) |=> rd_busy); // R4
  AST_SNAP_HELD: assert property (@(posedge clk) disable iff (rst)
    (!rd_busy && !$past(rd_busy)) |-> $stable(snap_q)); // R4
  AST_STATUS_STICKY: assert property (@(posedge clk) disable iff (rst)
    !(wr_en && hit_status) |=> ((status_q & $past(status_q)) == $past(status_q))); // R6
  AST_RST_NEEDS_ARM: assert property (@(posedge clk) disable iff (rst)
    $rose(wdrst_q) |-> $past(arm_q)); // R10
  AST_RST_STICKY: assert property (@(posedge clk) disable iff (rst)
    (wdrst_q && !(wr_en && hit_rstat && reg_wdata[BIT_WDRST])) |=> wdrst_q); // R11
endmodule

// File: rtl/wdt_ostimer.sv
module wdt_ostimer #(
  parameter int CNT_W     = 32,
  parameter int NUM_MATCH = 8,
  parameter int ADDR_W    = 8,
  parameter int SYNC_ST   = 2
) (
  input  logic              clk_bus,
  input  logic              rst_bus,
  input  logic              clk_tick,
  input  logic              rst_tick,
  input  logic              reg_sel,
  input  logic              reg_wr,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [CNT_W-1:0]  reg_wdata,
  output logic [CNT_W-1:0]  reg_rdata,
  output logic              irq,
  output logic              wdt_reset_req
);
  logic                       run_x, rd_req_x, wr_req_x, rd_ack_x, wr_ack_x;
  logic [CNT_W-1:0]           wr_val_x, snap_x;
  logic [NUM_MATCH*CNT_W-1:0] match_x;
  logic [NUM_MATCH-1:0]       hit_x;

  wdt_bus_regs #(
    .CNT_W(CNT_W), .NUM_MATCH(NUM_MATCH), .ADDR_W(ADDR_W), .SYNC_ST(SYNC_ST)
  ) u_bus (
    .clk(clk_bus), .rst(rst_bus),
    .reg_sel(reg_sel), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .irq(irq), .wdt_reset_req(wdt_reset_req),
    .run_out(run_x), .rd_req_tgl(rd_req_x), .wr_req_tgl(wr_req_x),
    .wr_val(wr_val_x), .match_flat(match_x),
    .rd_ack_tgl(rd_ack_x), .wr_ack_tgl(wr_ack_x),
    .tick_snap(snap_x), .hit_tgl(hit_x));

  wdt_tick_core #(
    .CNT_W(CNT_W), .NUM_MATCH(NUM_MATCH), .SYNC_ST(SYNC_ST)
  ) u_tick (
    .clk(clk_tick), .rst(rst_tick),
    .run_async(run_x), .rd_req_tgl(rd_req_x), .wr_req_tgl(wr_req_x),
    .wr_val(wr_val_x), .match_flat(match_x),
    .rd_ack_tgl(rd_ack_x), .wr_ack_tgl(wr_ack_x),
    .snap(snap_x), .hit_tgl(hit_x));
endmodule

// File: tb/tb_wdt_ostimer.sv
module tb_wdt_ostimer;
  localparam int CW = 32;
  localparam int NM = 8;
  localparam int AW = 8;
  localparam logic [AW-1:0] A_CTRL = 8'h00, A_ACC = 8'h04, A_CNT = 8'h08,
                            A_STAT = 8'h0C, A_IEN = 8'h10, A_ARM = 8'h14,
                            A_RST  = 8'h18, A_M0  = 8'h20;
  // load value / expected readback with the counter stopped
  localparam logic [63:0] VEC [5] = '{
    {32'h0000_1234, 32'h0000_1234},
    {32'hFFFF_FFFF, 32'hFFFF_FFFF},
    {32'hA5A5_5A5A, 32'hA5A5_5A5A},
    {32'h8000_0001, 32'h8000_0001},
    {32'h0000_0000, 32'h0000_0000}};

  logic clk_bus = 0, clk_tick = 0, rst_bus = 1, rst_tick = 1;
  logic reg_sel = 0, reg_wr = 0;
  logic [AW-1:0] reg_addr = '0;
  logic [CW-1:0] reg_wdata = '0;
  logic [CW-1:0] reg_rdata;
  logic irq, wdt_reset_req;
  int n_chk = 0, n_bad = 0, req_cycles = 0;
  logic run_st = 0;

  always #10 clk_bus = ~clk_bus;
  always #30 clk_tick = ~clk_tick;
  always @(posedge clk_bus) if (wdt_reset_req === 1'b1) req_cycles++;

  wdt_ostimer #(.CNT_W(CW), .NUM_MATCH(NM), .ADDR_W(AW)) dut (
    .clk_bus(clk_bus), .rst_bus(rst_bus), .clk_tick(clk_tick), .rst_tick(rst_tick),
    .reg_sel(reg_sel), .reg_wr(reg_wr), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata), .irq(irq), .wdt_reset_req(wdt_reset_req));

  task automatic chk(input string tag, input logic [CW-1:0] act, input logic [CW-1:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [AW-1:0] a, input logic [CW-1:0] d);
    @(negedge clk_bus);
    reg_sel = 1; reg_wr = 1; reg_addr = a; reg_wdata = d;
    @(negedge clk_bus);
    reg_sel = 0; reg_wr = 0;
  endtask

  task automatic rd(input logic [AW-1:0] a, output logic [CW-1:0] d);
    @(negedge clk_bus);
    reg_sel = 1; reg_wr = 0; reg_addr = a;
    @(negedge clk_bus);
    reg_sel = 0;
    d = reg_rdata;
  endtask

  task automatic wait_acc_clear(input int bitn);
    logic [CW-1:0] v;
    for (int k = 0; k < 200; k++) begin
      rd(A_ACC, v);
      if (v[bitn] == 1'b0) return;
    end
  endtask

  task automatic load_count(input logic [CW-1:0] v);
    wait_acc_clear(1);
    wr(A_CNT, v);
    wait_acc_clear(1);
  endtask

  task automatic read_count(output logic [CW-1:0] v);
    wr(A_CTRL, {30'd0, 1'b1, run_st});
    wait_acc_clear(0);
    rd(A_CNT, v);
  endtask

  task automatic set_run(input logic r);
    run_st = r;
    wr(A_CTRL, {31'd0, r});
    repeat (12) @(negedge clk_bus);
  endtask

  task automatic wait_bit(input logic [AW-1:0] a, input int bitn);
    logic [CW-1:0] v;
    for (int k = 0; k < 400; k++) begin
      rd(a, v);
      if (v[bitn]) return;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk_bus);
    n_chk++; n_bad++;
    $display("FAIL timeout actual=running expected=finished");
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    logic [CW-1:0] v, c1, c2;
    int base;
    repeat (6) @(posedge clk_tick);
    @(negedge clk_bus); rst_bus = 0; rst_tick = 0;
    repeat (4) @(negedge clk_bus);

    // R1 reset state
    rd(A_CTRL, v); chk("R1 ctrl", v, 0);
    rd(A_ACC, v);  chk("R1 access", v, 0);
    rd(A_CNT, v);  chk("R1 count", v, 0);
    rd(A_STAT, v); chk("R1 status", v, 0);
    rd(A_ARM, v);  chk("R1 arm", v, 0);
    rd(A_RST, v);  chk("R1 rstat", v, 0);
    chk("R1 irq", {31'd0, irq}, 0);
    chk("R1 reset_req", {31'd0, wdt_reset_req}, 0);

    // R2 table of loads with the counter stopped
    foreach (VEC[i]) begin
      wait_acc_clear(1);
      wr(A_CNT, VEC[i][63:32]);
      if (i == 0) begin
        rd(A_ACC, v); chk("R2 write busy set", {31'd0, v[1]}, 1);
      end
      wait_acc_clear(1);
      rd(A_ACC, v); chk("R2 write busy clear", {31'd0, v[1]}, 0);
      read_count(v); chk("R2 readback", v, VEC[i][31:0]);
    end

    // R3 second write while busy is dropped
    wait_acc_clear(1);
    wr(A_CNT, 32'h0000_1111);
    wr(A_CNT, 32'h0000_2222);
    wait_acc_clear(1);
    read_count(v); chk("R3 busy write ignored", v, 32'h0000_1111);

    // R4 read handshake and held snapshot while running
    set_run(1);
    wr(A_CTRL, 32'h3);
    rd(A_ACC, v); chk("R4 read busy set", {31'd0, v[0]}, 1);
    wait_acc_clear(0);
    rd(A_ACC, v); chk("R4 read busy clear", {31'd0, v[0]}, 0);
    rd(A_CNT, c1);
    repeat (30) @(negedge clk_bus);
    rd(A_CNT, c2); chk("R4 snapshot held", c2, c1);

    // R5 advances while running, holds when stopped
    read_count(c2);
    chk("R5 advanced", {31'd0, (c2 > c1)}, 1);
    set_run(0);
    read_count(c1);
    repeat (40) @(negedge clk_bus);
    read_count(c2); chk("R5 holds stopped", c2, c1);

    // R6 R7 R8 wrap match on match3, match2 masked
    wr(A_STAT, '1);
    wr(A_M0 + 8'd12, 32'd1);
    wr(A_M0 + 8'd8, 32'hFFFF_FFFF);
    wr(A_IEN, 32'h8);
    load_count(32'hFFFF_FFFD);
    wr(A_STAT, '1);
    repeat (20) @(negedge clk_bus);
    set_run(1);
    wait_bit(A_STAT, 3);
    rd(A_STAT, v);
    chk("R8 wrap match3", {31'd0, v[3]}, 1);
    chk("R6 match2 set", {31'd0, v[2]}, 1);
    chk("R7 irq enabled", {31'd0, irq}, 1);
    read_count(v); chk("R8 count wrapped", {31'd0, (v < 32'd400)}, 1);
    set_run(0);
    repeat (10) @(negedge clk_bus);
    rd(A_STAT, v); chk("R6 sticky", {31'd0, v[3]}, 1);
    wr(A_STAT, 32'h8);
    repeat (2) @(negedge clk_bus);
    rd(A_STAT, v);
    chk("R6 w1c bit3", {31'd0, v[3]}, 0);
    chk("R6 bit2 kept", {31'd0, v[2]}, 1);
    chk("R7 irq masked", {31'd0, irq}, 0);

    // R9 R11 armed watchdog
    wr(A_STAT, '1);
    wr(A_M0, 32'd200);
    load_count(32'd150);
    repeat (20) @(negedge clk_bus);
    wr(A_ARM, 32'd1);
    set_run(1);
    wait_bit(A_RST, 3);
    rd(A_RST, v); chk("R9 reset status", v, 32'h8);
    chk("R9 reset request", {31'd0, wdt_reset_req}, 1);
    set_run(0);
    wr(A_ARM, 32'd0);
    wr(A_RST, 32'h0);
    rd(A_RST, v); chk("R11 write 0 no effect", v, 32'h8);
    wr(A_RST, 32'h8);
    @(negedge clk_bus);
    rd(A_RST, v); chk("R11 cleared", v, 0);
    chk("R11 request dropped", {31'd0, wdt_reset_req}, 0);

    // R10 disarmed watchdog
    wr(A_STAT, '1);
    wr(A_M0, 32'd320);
    load_count(32'd300);
    repeat (20) @(negedge clk_bus);
    base = req_cycles;
    set_run(1);
    wait_bit(A_STAT, 0);
    rd(A_STAT, v); chk("R10 match0 status", {31'd0, v[0]}, 1);
    rd(A_RST, v);  chk("R10 no reset status", v, 0);
    chk("R10 no request", base, req_cycles);
    set_run(0);

    // R12 keepalive
    wr(A_M0, 32'd40);
    load_count(32'd0);
    repeat (20) @(negedge clk_bus);
    wr(A_ARM, 32'd1);
    base = req_cycles;
    set_run(1);
    for (int k = 0; k < 12; k++) begin
      read_count(c1);
      wr(A_M0, c1 + 32'd30);
      repeat (15) @(negedge clk_bus);
    end
    read_count(c1);
    chk("R12 ran past first deadline", {31'd0, (c1 > 32'd60)}, 1);
    chk("R12 no request", base, req_cycles);
    rd(A_RST, v); chk("R12 no reset status", v, 0);
    set_run(0);
    wr(A_ARM, 32'd0);

    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule